// File: doc/BRIEF.md
# Filtered Cache Event Counter

This block counts cache transactions that survive a stack of programmable filters. Every cycle, an upstream monitor may present one transaction on a strobe-qualified event bus. A transaction carries five fields: the index of the issuing core or thread, a 3-bit request-type code, a 5-bit code naming where the data came from, and 11-bit source and target cluster IDs. Each ID is built from a 6-bit cluster-group number in its upper bits and a 5-bit sub-cluster number in its lower bits.

Five filters can be switched on independently: a core bitmap, an exact request-type match, an exact data-source match, and masked compares on the source ID and on the target ID. A transaction adds one to the event count only when it passes every filter that is switched on and counting is enabled. With no filter switched on, every transaction is counted. Software reaches the configuration, the count and a sticky overflow flag through a small write-strobe and read-address register port. The count width is a parameter and defaults to 48 bits.

Top module: `evt_filter_counter`

## Requirements
- R1: After reset the count, the overflow flag, the count enable, every filter enable and every configuration field are zero. Reading address 0 and address 5 returns 0.
- R2: When filtering is off and the count enable (address 0 bit 0) is 1, each cycle with `evt_valid` high adds exactly one to the count. Cycles with `evt_valid` low leave the count unchanged. While the count enable is 0, events leave the count unchanged.
- R3: When the core filter (address 0 bit 4) is on, an event is counted only if bit `evt_core` of the core bitmap (address 1) is set. For example, bitmap 0x3 admits only cores 0 and 1.
- R4: When the request filter (address 0 bit 5) is on, an event is counted only if `evt_req` equals the selected code (address 2 bits 2:0). The codes are 3'b100 read, 3'b101 write, 3'b110 atomic store and 3'b111 atomic non-store; the other codes are reserved. When this filter is off, every request type is counted.
- R5: When the data-source filter (address 0 bit 6) is on, an event is counted only if `evt_src` equals the selected 5-bit code (address 2 bits 12:8). Examples: 5'b00001 is the local-die cache, 5'b01110 is local DRAM and 5'b10000 is cross-socket DRAM.
- R6: When the source-ID filter (address 0 bit 7) is on, an event is counted only if `evt_sid` equals the compare value (address 3 bits 10:0) in every bit where the mask (address 3 bits 26:16) is 0. A mask bit that is set excludes that bit from the compare. A mask of 11'h01F therefore matches on the 6-bit group only.
- R7: The target-ID filter (address 0 bit 8) applies the same masked compare to `evt_tid`, using address 4 (compare value in bits 10:0, mask in bits 26:16).
- R8: The results of all filters that are on are ANDed. An event that fails any one of them is not counted. When all filters are off, no field is checked.
- R9: A configuration write takes effect on the edge after the write edge. An event sampled on the same edge as the write is judged with the old settings.
- R10: Writing address 0 with bit 1 set clears the count to zero on that edge. The clear takes priority over an event accepted on the same edge.
- R11: An accepted event while the count is all ones wraps the count to zero and sets the sticky overflow flag (`ovf` and address 6 bit 31). The flag stays set until address 0 is written with bit 2 set; a new wrap on that same edge wins over the clear.
- R12: Reads are combinational. Address 5 returns count bits 31:0 and address 6 returns the count bits above 31 in bits 30:0 with the overflow flag in bit 31. Address 0 reads back the count enable in bit 0 and the filter enables in bits 8:4. Every write to address 0 also rewrites those enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | One-cycle strobe marking a transaction |
| evt_core | input | CORE_W | Core/thread index of the transaction |
| evt_req | input | 3 | Request-type code |
| evt_src | input | 5 | Data-source code |
| evt_sid | input | 11 | Source cluster ID {group, sub} |
| evt_tid | input | 11 | Target cluster ID {group, sub} |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| ovf | output | 1 | Sticky overflow flag |

## Verification
An event strobed on one clock edge shows in the count, and in the read data, just after that same edge. The read data itself is combinational, so it changes in the cycle that `rd_addr` changes. A register write lands on the edge where `wr_en` is high, and it filters events from the following edge onward. The clear and the overflow-clear act on the write edge itself. The bench drives every stimulus on a falling edge and samples one falling edge later, which is the first point where each result is due. The same-edge cases (write with event, clear with event, wrap followed by flag clear) are placed on a single rising edge on purpose.

// File: rtl/evtf_pkg.sv
package evtf_pkg;
   localparam int REQ_W = 3;
   localparam int SRC_W = 5;
   localparam int GRP_W = 6;
   localparam int SUB_W = 5;
   localparam int ID_W  = GRP_W + SUB_W;
   localparam int ADR_W = 3;
   localparam int NFILT = 5;

   localparam int F_CORE = 0;
   localparam int F_REQ  = 1;
   localparam int F_SRC  = 2;
   localparam int F_SID  = 3;
   localparam int F_TID  = 4;

   typedef enum logic [ADR_W-1:0] {
      A_CTRL = 3'd0,
      A_CMAP = 3'd1,
      A_SEL  = 3'd2,
      A_SID  = 3'd3,
      A_TID  = 3'd4,
      A_CLO  = 3'd5,
      A_CHI  = 3'd6
   } addr_e;

   typedef struct packed {
      logic             cnt_en;
      logic [NFILT-1:0] fen;
      logic [REQ_W-1:0] req;
      logic [SRC_W-1:0] src;
      logic [ID_W-1:0]  sid_cmp;
      logic [ID_W-1:0]  sid_msk;
      logic [ID_W-1:0]  tid_cmp;
      logic [ID_W-1:0]  tid_msk;
   } cfg_t;
endpackage

// File: rtl/evtf_cfg_regs.sv
module evtf_cfg_regs
   import evtf_pkg::*;
#(
   parameter int NCORE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADR_W-1:0]  wr_addr,
   input  logic [31:0]       wr_data,
   output cfg_t              cfg,
   output logic [NCORE-1:0]  cmap,
   output logic              cnt_clr,
   output logic              ovf_clr
);
   logic unused_wr;
   assign unused_wr = ^wr_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg  <= '0;
         cmap <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            A_CTRL: begin
               cfg.cnt_en <= wr_data[0];
               cfg.fen    <= wr_data[8:4];
            end
            A_CMAP: cmap <= wr_data[NCORE-1:0];
            A_SEL: begin
               cfg.req <= wr_data[2:0];
               cfg.src <= wr_data[12:8];
            end
            A_SID: begin
               cfg.sid_cmp <= wr_data[10:0];
               cfg.sid_msk <= wr_data[26:16];
            end
            A_TID: begin
               cfg.tid_cmp <= wr_data[10:0];
               cfg.tid_msk <= wr_data[26:16];
            end
            default: ;
         endcase
      end
   end

   assign cnt_clr = wr_en && (wr_addr == A_CTRL) && wr_data[1];
   assign ovf_clr = wr_en && (wr_addr == A_CTRL) && wr_data[2];

   assert_sid_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_addr == A_SID |=> cfg.sid_cmp == $past(wr_data[10:0]));
   assert_ctrl_wr_R12: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_addr == A_CTRL |=> cfg.fen == $past(wr_data[8:4]));
endmodule

// File: rtl/evtf_id_cmp.sv
module evtf_id_cmp #(
   parameter int W = 11
) (
   input  logic [W-1:0] id,
   input  logic [W-1:0] cmp,
   input  logic [W-1:0] msk,
   output logic         eq
);
   assign eq = ((id ^ cmp) & ~msk) == '0;
endmodule

// File: rtl/evtf_match.sv
module evtf_match
   import evtf_pkg::*;
#(
   parameter int CORE_W = 4,
   localparam int NCORE = 1 << CORE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_valid,
   input  logic [CORE_W-1:0] evt_core,
   input  logic [REQ_W-1:0]  evt_req,
   input  logic [SRC_W-1:0]  evt_src,
   input  logic [ID_W-1:0]   evt_sid,
   input  logic [ID_W-1:0]   evt_tid,
   input  cfg_t              cfg,
   input  logic [NCORE-1:0]  cmap,
   output logic              hit
);
   logic [NFILT-1:0] pass;
   logic [ID_W-1:0]  id_in  [2];
   logic [ID_W-1:0]  id_cmp [2];
   logic [ID_W-1:0]  id_msk [2];
   logic [1:0]       id_eq;

   assign id_in[0]  = evt_sid;
   assign id_cmp[0] = cfg.sid_cmp;
   assign id_msk[0] = cfg.sid_msk;
   assign id_in[1]  = evt_tid;
   assign id_cmp[1] = cfg.tid_cmp;
   assign id_msk[1] = cfg.tid_msk;

   for (genvar gi = 0; gi < 2; gi++) begin : g_id
      evtf_id_cmp #(.W(ID_W)) u_cmp (
         .id  (id_in[gi]),
         .cmp (id_cmp[gi]),
         .msk (id_msk[gi]),
         .eq  (id_eq[gi])
      );
   end

   always_comb begin
      pass[F_CORE] = !cfg.fen[F_CORE] || cmap[evt_core];
      pass[F_REQ]  = !cfg.fen[F_REQ]  || (evt_req == cfg.req);
      pass[F_SRC]  = !cfg.fen[F_SRC]  || (evt_src == cfg.src);
      pass[F_SID]  = !cfg.fen[F_SID]  || id_eq[0];
      pass[F_TID]  = !cfg.fen[F_TID]  || id_eq[1];
   end

   assign hit = evt_valid && (&pass);

   assert_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid && cfg.fen == '0 |-> hit);
   assert_core_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit && cfg.fen[F_CORE] |-> cmap[evt_core]);
   assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_valid |-> !hit);
endmodule

// File: rtl/evtf_counter.sv
module evtf_counter #(
   parameter int CNT_W = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             clr,
   input  logic             ovf_clr,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic wrap;
   assign wrap = inc && !clr && (&cnt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         ovf <= 1'b0;
      end else begin
         if (clr)      cnt <= '0;
         else if (inc) cnt <= cnt + ONE;
         if (wrap)         ovf <= 1'b1;
         else if (ovf_clr) ovf <= 1'b0;
      end
   end

   assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt == '0);
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !clr && !inc |=> $stable(cnt));
   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !clr && inc |=> cnt == $past(cnt) + ONE);
   assert_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
      inc && !clr && (&cnt) |=> ovf && cnt == '0);
   assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ovf && !ovf_clr |=> ovf);
endmodule

// File: rtl/evt_filter_counter.sv
module evt_filter_counter
   import evtf_pkg::*;
#(
   parameter int CORE_W = 4,
   parameter int CNT_W  = 48,
   localparam int NCORE = 1 << CORE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_valid,
   input  logic [CORE_W-1:0] evt_core,
   input  logic [2:0]        evt_req,
   input  logic [4:0]        evt_src,
   input  logic [10:0]       evt_sid,
   input  logic [10:0]       evt_tid,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [2:0]        rd_addr,
   output logic [31:0]       rd_data,
   output logic              ovf
);
   if (CORE_W < 1 || CORE_W > 5) begin : g_bad_core
      $error("CORE_W must be 1..5 so the bitmap fits one register");
   end
   if (CNT_W < 8 || CNT_W > 63) begin : g_bad_cnt
      $error("CNT_W must be 8..63");
   end

   cfg_t             cfg;
   logic [NCORE-1:0] cmap;
   logic             cnt_clr;
   logic             ovf_clr;
   logic             hit;
   logic [CNT_W-1:0] cnt;
   logic [62:0]      cnt_ext;

   evtf_cfg_regs #(.NCORE(NCORE)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .cfg     (cfg),
      .cmap    (cmap),
      .cnt_clr (cnt_clr),
      .ovf_clr (ovf_clr)
   );

   evtf_match #(.CORE_W(CORE_W)) u_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_valid (evt_valid),
      .evt_core  (evt_core),
      .evt_req   (evt_req),
      .evt_src   (evt_src),
      .evt_sid   (evt_sid),
      .evt_tid   (evt_tid),
      .cfg       (cfg),
      .cmap      (cmap),
      .hit       (hit)
   );

   evtf_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (hit && cfg.cnt_en),
      .clr     (cnt_clr),
      .ovf_clr (ovf_clr),
      .cnt     (cnt),
      .ovf     (ovf)
   );

   always_comb begin
      cnt_ext = '0;
      cnt_ext[CNT_W-1:0] = cnt;
      rd_data = '0;
      case (rd_addr)
         A_CTRL: begin
            rd_data[0]   = cfg.cnt_en;
            rd_data[8:4] = cfg.fen;
         end
         A_CMAP: rd_data[NCORE-1:0] = cmap;
         A_SEL: begin
            rd_data[2:0]  = cfg.req;
            rd_data[12:8] = cfg.src;
         end
         A_SID: begin
            rd_data[10:0]  = cfg.sid_cmp;
            rd_data[26:16] = cfg.sid_msk;
         end
         A_TID: begin
            rd_data[10:0]  = cfg.tid_cmp;
            rd_data[26:16] = cfg.tid_msk;
         end
         A_CLO: rd_data = cnt_ext[31:0];
         A_CHI: rd_data = {ovf, cnt_ext[62:32]};
         default: rd_data = '0;
      endcase
   end

   assert_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.cnt_en && !cnt_clr |=> $stable(cnt));
endmodule

// File: tb/evt_filter_counter_bench.sv
module evt_filter_counter_bench;
   localparam int CORE_W = 4;
   localparam int CNT_W  = 10;

   typedef struct packed {
      logic [4:0]  fen;
      logic [15:0] cmap;
      logic [2:0]  req;
      logic [4:0]  src;
      logic [10:0] scmp;
      logic [10:0] smsk;
      logic [10:0] tcmp;
      logic [10:0] tmsk;
      logic [3:0]  ecore;
      logic [2:0]  ereq;
      logic [4:0]  esrc;
      logic [10:0] esid;
      logic [10:0] etid;
      logic        exp;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t TBL [NV] = '{
      // R2 R8: all filters off, any fields counted
      '{5'h00,16'h0000,3'd0,5'h00,11'h000,11'h000,11'h000,11'h000,4'd7, 3'd2,5'h03,11'h055,11'h0AA,1'b1},
      // R3: bitmap 0x3 admits core 1
      '{5'h01,16'h0003,3'd0,5'h00,11'h000,11'h000,11'h000,11'h000,4'd1, 3'd0,5'h00,11'h000,11'h000,1'b1},
      // R3: bitmap 0x3 rejects core 2
      '{5'h01,16'h0003,3'd0,5'h00,11'h000,11'h000,11'h000,11'h000,4'd2, 3'd0,5'h00,11'h000,11'h000,1'b0},
      // R3: top core
      '{5'h01,16'h8000,3'd0,5'h00,11'h000,11'h000,11'h000,11'h000,4'd15,3'd0,5'h00,11'h000,11'h000,1'b1},
      // R4: read selected, read arrives
      '{5'h02,16'h0000,3'd4,5'h00,11'h000,11'h000,11'h000,11'h000,4'd0, 3'd4,5'h00,11'h000,11'h000,1'b1},
      // R4: read selected, write arrives
      '{5'h02,16'h0000,3'd4,5'h00,11'h000,11'h000,11'h000,11'h000,4'd0, 3'd5,5'h00,11'h000,11'h000,1'b0},
      // R4: filter off, atomic non-store counted
      '{5'h00,16'h0000,3'd4,5'h00,11'h000,11'h000,11'h000,11'h000,4'd0, 3'd7,5'h00,11'h000,11'h000,1'b1},
      // R5: local DRAM matches
      '{5'h04,16'h0000,3'd0,5'h0E,11'h000,11'h000,11'h000,11'h000,4'd0, 3'd0,5'h0E,11'h000,11'h000,1'b1},
      // R5: cross-die DRAM rejected
      '{5'h04,16'h0000,3'd0,5'h0E,11'h000,11'h000,11'h000,11'h000,4'd0, 3'd0,5'h0F,11'h000,11'h000,1'b0},
      // R6: group 3 match, sub bits masked
      '{5'h08,16'h0000,3'd0,5'h00,11'h060,11'h01F,11'h000,11'h000,4'd0, 3'd0,5'h00,11'h069,11'h000,1'b1},
      // R6: group 4 rejected
      '{5'h08,16'h0000,3'd0,5'h00,11'h060,11'h01F,11'h000,11'h000,4'd0, 3'd0,5'h00,11'h089,11'h000,1'b0},
      // R7: exact target match
      '{5'h10,16'h0000,3'd0,5'h00,11'h000,11'h000,11'h123,11'h000,4'd0, 3'd0,5'h00,11'h000,11'h123,1'b1},
      // R7: one bit off
      '{5'h10,16'h0000,3'd0,5'h00,11'h000,11'h000,11'h123,11'h000,4'd0, 3'd0,5'h00,11'h000,11'h122,1'b0},
      // R8: all on, all pass
      '{5'h1F,16'h0080,3'd6,5'h10,11'h060,11'h01F,11'h7FF,11'h7FF,4'd7, 3'd6,5'h10,11'h07C,11'h000,1'b1},
      // R8: all on, only data source fails
      '{5'h1F,16'h0080,3'd6,5'h10,11'h060,11'h01F,11'h7FF,11'h7FF,4'd7, 3'd6,5'h01,11'h07C,11'h000,1'b0}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              evt_valid = 1'b0;
   logic [CORE_W-1:0] evt_core = '0;
   logic [2:0]        evt_req = '0;
   logic [4:0]        evt_src = '0;
   logic [10:0]       evt_sid = '0;
   logic [10:0]       evt_tid = '0;
   logic              wr_en = 1'b0;
   logic [2:0]        wr_addr = '0;
   logic [31:0]       wr_data = '0;
   logic [2:0]        rd_addr = '0;
   logic [31:0]       rd_data;
   logic              ovf;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   evt_filter_counter #(.CORE_W(CORE_W), .CNT_W(CNT_W)) u_evt_filter_counter (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_core(evt_core),
      .evt_req(evt_req), .evt_src(evt_src), .evt_sid(evt_sid), .evt_tid(evt_tid),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .ovf(ovf)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic burst(input int n);
      @(negedge clk);
      evt_valid = 1'b1;
      repeat (n) @(negedge clk);
      evt_valid = 1'b0;
   endtask

   function automatic logic [31:0] ctrl(input logic [4:0] fen, input logic oclr,
                                        input logic clr, input logic en);
      return {23'b0, fen, 1'b0, oclr, clr, en};
   endfunction

   initial begin
      #(4 * 150000);
      if (!done) begin
         nerr++;
         nchk++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(3'd0, d); check("R1 ctrl", d, 32'h0);
      rd(3'd5, d); check("R1 count", d, 32'h0);
      check("R1 ovf", {31'b0, ovf}, 32'h0);

      // table walk: R3..R8
      for (int i = 0; i < NV; i++) begin
         wr(3'd1, {16'b0, TBL[i].cmap});
         wr(3'd2, {19'b0, TBL[i].src, 5'b0, TBL[i].req});
         wr(3'd3, {5'b0, TBL[i].smsk, 5'b0, TBL[i].scmp});
         wr(3'd4, {5'b0, TBL[i].tmsk, 5'b0, TBL[i].tcmp});
         wr(3'd0, ctrl(TBL[i].fen, 1'b0, 1'b1, 1'b1));
         evt_core = TBL[i].ecore; evt_req = TBL[i].ereq; evt_src = TBL[i].esrc;
         evt_sid = TBL[i].esid; evt_tid = TBL[i].etid;
         burst(1);
         rd(3'd5, d);
         check($sformatf("R3-R8 table row %0d", i), d, {31'b0, TBL[i].exp});
      end

      // R12 readback of enables
      rd(3'd0, d); check("R12 ctrl readback", d, 32'h1F1);

      // R2 counting, idle, disabled
      wr(3'd0, ctrl(5'h00, 1'b0, 1'b1, 1'b1));
      burst(5);
      rd(3'd5, d); check("R2 five events", d, 32'd5);
      repeat (3) @(negedge clk);
      rd(3'd5, d); check("R2 idle hold", d, 32'd5);
      wr(3'd0, ctrl(5'h00, 1'b0, 1'b0, 1'b0));
      burst(4);
      rd(3'd5, d); check("R2 disabled hold", d, 32'd5);

      // R9 write and event on the same edge
      wr(3'd1, 32'h0);
      wr(3'd0, ctrl(5'h00, 1'b0, 1'b1, 1'b1));
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'd0; wr_data = ctrl(5'h01, 1'b0, 1'b0, 1'b1);
      evt_valid = 1'b1; evt_core = 4'd3;
      @(negedge clk);
      wr_en = 1'b0; evt_valid = 1'b0;
      rd(3'd5, d); check("R9 old config used", d, 32'd1);
      burst(1);
      rd(3'd5, d); check("R9 new config used", d, 32'd1);

      // R10 clear against simultaneous event
      wr(3'd0, ctrl(5'h00, 1'b0, 1'b0, 1'b1));
      burst(3);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'd0; wr_data = ctrl(5'h00, 1'b0, 1'b1, 1'b1);
      evt_valid = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; evt_valid = 1'b0;
      rd(3'd5, d); check("R10 clear wins", d, 32'd0);
      burst(1);
      rd(3'd5, d); check("R10 count after clear", d, 32'd1);

      // R11 wrap and sticky flag
      wr(3'd0, ctrl(5'h00, 1'b0, 1'b1, 1'b1));
      burst((1 << CNT_W) - 1);
      rd(3'd5, d); check("R11 at all ones", d, 32'd1023);
      check("R11 no flag yet", {31'b0, ovf}, 32'h0);
      burst(1);
      rd(3'd5, d); check("R11 wrapped", d, 32'd0);
      rd(3'd6, d); check("R11 R12 flag in high word", d, 32'h8000_0000);
      burst(2);
      check("R11 flag sticky", {31'b0, ovf}, 32'h1);
      wr(3'd0, ctrl(5'h00, 1'b1, 1'b0, 1'b1));
      check("R11 flag cleared", {31'b0, ovf}, 32'h0);
      rd(3'd5, d); check("R11 count kept", d, 32'd2);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule